// File: doc/BRIEF.md
# Multicycle Three-Address Processor Core

This block is a small processor core that runs each instruction through a fixed chain of register transfers. An instruction word is fetched from an external synchronous memory and decoded. It is then executed in an arithmetic unit, with an optional pair of data-memory steps, and finished by a write-back step. The core keeps a program counter, a memory address register, a memory data register, an instruction register, an accumulator, four general registers and a six-bit status register.

The memory is word addressed and has one cycle of read latency. The core drives the address and, for a store, the write data and a one-cycle write strobe. The read word returns on the data input in the cycle after the address was presented. A halt output marks a halted core. Debug outputs expose the sequencer step, the program counter, the accumulator, the flags and one general register picked by a select input.

Top module: `mcpu_core`

## Requirements
- R1: While reset is held, the program counter, flags, accumulator and all four registers read 0, halted and the write strobe are 0, and the step output is 0, which is the first fetch step.
- R2: Counting clock cycles from the first fetch step of an instruction to the first fetch step of the next, an instruction without a data-memory access takes 7 cycles, and LOAD and STORE take 9. A halt instruction raises halted 5 cycles after its first fetch step. During fetch, the word at the program counter is read and the counter advances by one.
- R3: The instruction word is {opcode, destination, source 1, source 2}, from the top byte down. ADD 0x02, SUB 0x03, MUL 0x04, AND 0x06, OR 0x07, NOT 0x08, XOR 0x09, SHL 0x0A and SHR 0x0B write source1 op source2 into the destination register and leave every other register unchanged, also when the destination names a source. NOT uses only source 1, MUL keeps the low 32 bits of the product, and the shift count is the low 5 bits of source 2.
- R4: The flags are {overflow, sign, zero, aux, parity, carry}, bit 5 down to bit 0. ADD sets carry from the unsigned carry-out, aux from the carry out of bit 3 and overflow from signed overflow. SUB sets carry and aux when the unsigned minuend, or its low nibble, is below the subtrahend, and sets overflow from signed overflow. For every flag-setting operation, zero means a zero result, sign is bit 31 of the result and parity is 1 when the low byte has an even number of ones.
- R5: MUL sets carry and overflow when the upper half of the 64-bit product is nonzero. AND, OR, NOT and XOR clear carry, aux and overflow. SHL and SHR set carry to the last bit shifted out, and to 0 for a count of 0. All of these clear aux, and the shifts also clear overflow.
- R6: MOV 0x01 copies source 1 into the destination without touching the flags. NOP, MOV, the jumps, LOAD, STORE and the halt instruction leave the flags unchanged.
- R7: JMP 0x0C loads the program counter from the destination field. JE 0x0D does so only when the zero flag is 1, and JNE 0x0E only when it is 0. Otherwise execution continues with the next word.
- R8: LOAD 0x13 writes the memory word at the address in the source 1 field into the destination register. STORE 0x14 writes the destination register to that address with a write strobe that lasts exactly one cycle.
- R9: Any opcode not listed here, other than 0xFF, changes no register or flag and takes 7 cycles like NOP 0x00.
- R10: Opcode 0xFF raises halted. From then until reset, the program counter stays frozen, halted stays high and memory is not written.
- R11: A register field selects a register by its low 2 bits only, and its upper 6 bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Word address to memory (memory address register) |
| mem_rdata | input | 32 | Read word, valid the cycle after the address |
| mem_wdata | output | 32 | Write word (memory data register) |
| mem_we | output | 1 | Write strobe, one cycle per store |
| halted | output | 1 | High once a halt instruction has been decoded |
| dbg_step | output | 4 | Sequencer step, 0 is the first fetch step |
| dbg_pc | output | 8 | Program counter |
| dbg_acc | output | 32 | Accumulator |
| dbg_flags | output | 6 | Flags {overflow, sign, zero, aux, parity, carry} |
| dbg_reg_sel | input | 2 | Register picked for dbg_reg |
| dbg_reg | output | 32 | Content of the selected general register |

## Verification
Every arithmetic and logic opcode is run against nine operand pairs: zeros, equal values, an all-ones word, the signed limits, a nibble carry, mixed patterns and shift counts of 0, 1, 16 and 31. The pairs separate the carry, aux and overflow rules from one another and catch a reversed or miscounted shift. Each case also runs with a destination that aliases a source, and with junk in the upper field bits, to tell three-address write-back from in-place update. Branch programs cover equal and unequal compares under each jump kind, which shows whether the condition is the zero flag or its inverse. A sweep of unlisted opcodes, plus MOV, shows that only the defined opcodes alter registers or flags. The instruction cycle counts tell the 7-step path apart from the 9-step memory path.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  typedef enum logic [7:0] {
    OP_NOP   = 8'h00,
    OP_MOV   = 8'h01,
    OP_ADD   = 8'h02,
    OP_SUB   = 8'h03,
    OP_MUL   = 8'h04,
    OP_AND   = 8'h06,
    OP_OR    = 8'h07,
    OP_NOT   = 8'h08,
    OP_XOR   = 8'h09,
    OP_SHL   = 8'h0A,
    OP_SHR   = 8'h0B,
    OP_JMP   = 8'h0C,
    OP_JE    = 8'h0D,
    OP_JNE   = 8'h0E,
    OP_LOAD  = 8'h13,
    OP_STORE = 8'h14,
    OP_HALT  = 8'hFF
  } opcode_e;

  typedef enum logic [3:0] {
    ST_PC2MAR  = 4'd0,
    ST_MWAIT   = 4'd1,
    ST_MEM2MDR = 4'd2,
    ST_MDR2IR  = 4'd3,
    ST_DECODE  = 4'd4,
    ST_EXEC    = 4'd5,
    ST_MACC_A  = 4'd6,
    ST_MACC_B  = 4'd7,
    ST_WBACK   = 4'd8,
    ST_HALT    = 4'd9
  } step_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  // Opcodes that compute in the ALU and update the flags.
  function automatic logic is_alu_op(logic [7:0] op);
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR,
      OP_NOT, OP_XOR, OP_SHL, OP_SHR: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic is_mem_op(logic [7:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  // Even parity of the low byte: 1 when the number of ones is even.
  function automatic logic even_par8(logic [7:0] v);
    return ~^v;
  endfunction

endpackage

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output flags_t            flg
);
  localparam int MSB  = DATA_W - 1;
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W:0]     sum;
  logic [4:0]          nib;
  logic [2*DATA_W-1:0] wide;
  logic [SH_W-1:0]     sh;

  assign sh = b[SH_W-1:0];

  always_comb begin
    sum  = '0;
    nib  = '0;
    wide = '0;
    res  = a;
    flg  = '0;
    case (op)
      OP_ADD: begin
        sum     = {1'b0, a} + {1'b0, b};
        nib     = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        res     = sum[MSB:0];
        flg.cry = sum[DATA_W];
        flg.aux = nib[4];
        flg.ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        sum     = {1'b0, a} - {1'b0, b};
        nib     = {1'b0, a[3:0]} - {1'b0, b[3:0]};
        res     = sum[MSB:0];
        flg.cry = sum[DATA_W];
        flg.aux = nib[4];
        flg.ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_MUL: begin
        wide    = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        res     = wide[MSB:0];
        flg.cry = |wide[2*DATA_W-1:DATA_W];
        flg.ovf = |wide[2*DATA_W-1:DATA_W];
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_NOT: res = ~a;
      OP_XOR: res = a ^ b;
      OP_SHL: begin
        wide    = {{DATA_W{1'b0}}, a} << sh;
        res     = wide[MSB:0];
        flg.cry = wide[DATA_W];
      end
      OP_SHR: begin
        wide    = {a, {DATA_W{1'b0}}} >> sh;
        res     = wide[2*DATA_W-1:DATA_W];
        flg.cry = wide[MSB];
      end
      default: res = a;
    endcase
    flg.zro = (res == '0);
    flg.sgn = res[MSB];
    flg.par = even_par8(res[7:0]);
  end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 4,
  localparam int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RSEL_W-1:0] ra_addr,
  output logic [DATA_W-1:0] ra_data,
  input  logic [RSEL_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_data,
  input  logic [RSEL_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rd_data = regs[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_hold
    // R3
    reg_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (waddr == RSEL_W'(g))) |=> $stable(regs[g]));
  end

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
  import mcpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] op,
  output step_e      step
);
  step_e nxt;

  always_comb begin
    case (step)
      ST_PC2MAR:  nxt = ST_MWAIT;
      ST_MWAIT:   nxt = ST_MEM2MDR;
      ST_MEM2MDR: nxt = ST_MDR2IR;
      ST_MDR2IR:  nxt = ST_DECODE;
      ST_DECODE:  nxt = (op == OP_HALT) ? ST_HALT : ST_EXEC;
      ST_EXEC:    nxt = is_mem_op(op) ? ST_MACC_A : ST_WBACK;
      ST_MACC_A:  nxt = ST_MACC_B;
      ST_MACC_B:  nxt = ST_WBACK;
      ST_WBACK:   nxt = ST_PC2MAR;
      ST_HALT:    nxt = ST_HALT;
      default:    nxt = ST_PC2MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= ST_PC2MAR;
    else        step <= nxt;
  end

  // R2
  exec_after_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC) |-> ($past(step) == ST_DECODE));

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int NREG    = 4,
  localparam int DATA_W = 4 * FIELD_W,
  localparam int ADDR_W = FIELD_W,
  localparam int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic [3:0]        dbg_step,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [5:0]        dbg_flags,
  input  logic [RSEL_W-1:0] dbg_reg_sel,
  output logic [DATA_W-1:0] dbg_reg
);
  logic [ADDR_W-1:0]  pc, mar;
  logic [DATA_W-1:0]  mdr, ir, acc, opa, opb;
  flags_t             flags;
  step_e              step;

  logic [FIELD_W-1:0] f_op, f_dst, f_s1, f_s2;
  logic [RSEL_W-1:0]  dst_sel, s1_sel, s2_sel, ra_sel;
  logic [DATA_W-1:0]  ra_data, rb_data, alu_res, wb_data;
  flags_t             alu_flg;
  logic               rf_we, is_alu, is_load, is_store;
  logic               unused_fields;

  assign {f_op, f_dst, f_s1, f_s2} = ir;
  assign dst_sel  = f_dst[RSEL_W-1:0];
  assign s1_sel   = f_s1[RSEL_W-1:0];
  assign s2_sel   = f_s2[RSEL_W-1:0];
  assign unused_fields = ^f_s2;

  assign is_alu   = is_alu_op(f_op);
  assign is_load  = (f_op == OP_LOAD);
  assign is_store = (f_op == OP_STORE);
  assign ra_sel   = is_store ? dst_sel : s1_sel;

  mcpu_seq u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (f_op),
    .step (step)
  );

  mcpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (dst_sel),
    .wdata  (wb_data),
    .ra_addr(ra_sel),
    .ra_data(ra_data),
    .rb_addr(s2_sel),
    .rb_data(rb_data),
    .rd_addr(dbg_reg_sel),
    .rd_data(dbg_reg)
  );

  mcpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op (f_op),
    .a  (opa),
    .b  (opb),
    .res(alu_res),
    .flg(alu_flg)
  );

  // Write-back: ALU result and MOV via the accumulator, LOAD via MDR.
  assign rf_we   = (step == ST_WBACK) && (is_alu || (f_op == OP_MOV) || is_load);
  assign wb_data = is_load ? mdr : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir    <= '0;
      acc   <= '0;
      opa   <= '0;
      opb   <= '0;
      flags <= '0;
    end else begin
      case (step)
        ST_PC2MAR:  mar <= pc;
        ST_MWAIT:   pc  <= pc + 1'b1;
        ST_MEM2MDR: mdr <= mem_rdata;
        ST_MDR2IR:  ir  <= mdr;
        ST_DECODE: begin
          opa <= ra_data;
          opb <= rb_data;
        end
        ST_EXEC: begin
          if (is_alu) begin
            acc   <= alu_res;
            flags <= alu_flg;
          end
          case (f_op)
            OP_MOV: acc <= alu_res;
            OP_JMP: pc  <= f_dst;
            OP_JE:  if (flags.zro)  pc <= f_dst;
            OP_JNE: if (!flags.zro) pc <= f_dst;
            OP_LOAD: mar <= f_s1;
            OP_STORE: begin
              mar <= f_s1;
              acc <= opa;
            end
            default: ;
          endcase
        end
        ST_MACC_A: if (is_store) mdr <= acc;
        ST_MACC_B: if (is_load)  mdr <= mem_rdata;
        default: ;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = (step == ST_MACC_B) && is_store;
  assign halted    = (step == ST_HALT);
  assign dbg_step  = step;
  assign dbg_pc    = pc;
  assign dbg_acc   = acc;
  assign dbg_flags = flags;

  // R8
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R8
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(acc)));

  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && !mem_we));

  // R6
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_EXEC) |=> $stable(flags));

  // R2
  fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_MEM2MDR) |-> (pc == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [3:0]  dbg_step;
  logic [7:0]  dbg_pc;
  logic [31:0] dbg_acc;
  logic [5:0]  dbg_flags;
  logic [1:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] image [256];
  logic [31:0] mem   [256];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= image[i];
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  mcpu_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .halted(halted), .dbg_step(dbg_step), .dbg_pc(dbg_pc), .dbg_acc(dbg_acc),
    .dbg_flags(dbg_flags), .dbg_reg_sel(dbg_reg_sel), .dbg_reg(dbg_reg)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input int sel, output logic [31:0] v);
    dbg_reg_sel = 2'(sel);
    #1;
    v = dbg_reg;
  endtask

  task automatic clear_image();
    for (int i = 0; i < 256; i++) image[i] = 32'h0;
  endtask

  function automatic logic [31:0] ins(logic [7:0] op, logic [7:0] d, logic [7:0] s1, logic [7:0] s2);
    return {op, d, s1, s2};
  endfunction

  // Holds reset, checks the reset state (R1), releases at a falling edge.
  task automatic do_reset(input bit check_it);
    logic [31:0] v;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (check_it) begin
      chk("R1 pc", 32'(dbg_pc), 32'h0);
      chk("R1 flags", 32'(dbg_flags), 32'h0);
      chk("R1 acc", dbg_acc, 32'h0);
      chk("R1 halted", 32'(halted), 32'h0);
      chk("R1 we", 32'(mem_we), 32'h0);
      chk("R1 step", 32'(dbg_step), 32'h0);
      for (int r = 0; r < 4; r++) begin
        rd_reg(r, v);
        chk("R1 reg", v, 32'h0);
      end
    end
    rst_n = 1'b1;
  endtask

  // Runs until halted; checks the cycle count (R2).
  task automatic run_prog(input int exp_cycles);
    int n = 0;
    while (!halted && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R2 cycles to halt", 32'(n), 32'(exp_cycles));
  endtask

  function automatic void ref_alu(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic [5:0] fl);
    logic c, ax, ov;
    logic [63:0] w;
    longint sa, sb, sl;
    int sh;
    c = 1'b0; ax = 1'b0; ov = 1'b0; r = '0;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    sh = int'(b[4:0]);
    case (op)
      8'h02: begin
        w = 64'(a) + 64'(b); r = w[31:0]; c = w[32];
        ax = ((a & 32'hF) + (b & 32'hF)) > 32'hF;
        sl = sa + sb; ov = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      8'h03: begin
        r = a - b; c = a < b; ax = (a & 32'hF) < (b & 32'hF);
        sl = sa - sb; ov = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
      end
      8'h04: begin
        w = 64'(a) * 64'(b); r = w[31:0]; c = (w[63:32] != 0); ov = c;
      end
      8'h06: r = a & b;
      8'h07: r = a | b;
      8'h08: r = ~a;
      8'h09: r = a ^ b;
      8'h0A: begin w = 64'(a) << sh; r = w[31:0]; c = w[32]; end
      8'h0B: begin r = a >> sh; c = (sh == 0) ? 1'b0 : a[sh-1]; end
      default: r = a;
    endcase
    fl = {ov, r[31], (r == 32'h0), ax, ~^r[7:0], c};
  endfunction

  function automatic logic [63:0] pair(int k);
    case (k)
      0: return {32'h0000_0000, 32'h0000_0000};
      1: return {32'h0000_0001, 32'h0000_0001};
      2: return {32'hFFFF_FFFF, 32'h0000_0001};
      3: return {32'h7FFF_FFFF, 32'h0000_0001};
      4: return {32'h8000_0000, 32'h8000_0000};
      5: return {32'h0000_000F, 32'h0000_0001};
      6: return {32'h1234_5678, 32'h9ABC_DEF0};
      7: return {32'h8000_0001, 32'h0000_001F};
      default: return {32'hC3A5_0F18, 32'h0000_0010};
    endcase
  endfunction

  // ALU case: LOAD R1; LOAD R2; OP d,R1,R2; STORE d,[0x82]; HALT.
  task automatic run_alu(logic [7:0] op, logic [31:0] a, logic [31:0] b, bit alias_dst, bit junk);
    logic [31:0] r, v;
    logic [5:0]  fl;
    logic [7:0]  d, s1, s2;
    int dsel;
    dsel = alias_dst ? 1 : 3;
    d  = junk ? (8'hA4 | 8'(dsel)) : 8'(dsel);
    s1 = junk ? 8'hF1 : 8'h01;
    s2 = junk ? 8'h5E : 8'h02;
    ref_alu(op, a, b, r, fl);
    clear_image();
    image[0] = ins(8'h13, 8'h01, 8'h80, 8'h00);
    image[1] = ins(8'h13, 8'h02, 8'h81, 8'h00);
    image[2] = ins(op, d, s1, s2);
    image[3] = ins(8'h14, d, 8'h82, 8'h00);
    image[4] = 32'hFF00_0000;
    image[8'h80] = a;
    image[8'h81] = b;
    do_reset(1'b0);
    run_prog(39);
    rd_reg(dsel, v);
    chk(junk ? "R3 R11 dest value" : "R3 dest value", v, r);
    rd_reg(2, v);
    chk("R3 source 2 kept", v, b);
    if (!alias_dst) begin
      rd_reg(1, v);
      chk("R3 source 1 kept", v, a);
    end
    rd_reg(0, v);
    chk("R3 other reg kept", v, 32'h0);
    chk((op == 8'h02 || op == 8'h03) ? "R4 flags" : "R5 flags", 32'(dbg_flags), 32'(fl));
    chk("R8 stored word", mem[8'h82], r);
  endtask

  // Branch case: SUB R3,R1,R2 then a jump to 6; word 4 loads a bad marker.
  task automatic run_branch(logic [7:0] op, logic [31:0] a, logic [31:0] b, bit taken);
    logic [31:0] r, v;
    logic [5:0]  fl;
    ref_alu(8'h03, a, b, r, fl);
    clear_image();
    image[0] = ins(8'h13, 8'h01, 8'h80, 8'h00);
    image[1] = ins(8'h13, 8'h02, 8'h81, 8'h00);
    image[2] = ins(8'h03, 8'h03, 8'h01, 8'h02);
    image[3] = ins(op, 8'h06, 8'h00, 8'h00);
    image[4] = ins(8'h13, 8'h00, 8'h83, 8'h00);
    image[5] = 32'hFF00_0000;
    image[6] = ins(8'h13, 8'h00, 8'h84, 8'h00);
    image[7] = 32'hFF00_0000;
    image[8'h80] = a;
    image[8'h81] = b;
    image[8'h83] = 32'h0000_0BAD;
    image[8'h84] = 32'h0000_600D;
    do_reset(1'b0);
    run_prog(46);
    rd_reg(0, v);
    chk("R7 path marker", v, taken ? 32'h600D : 32'h0BAD);
    chk("R7 final pc", 32'(dbg_pc), taken ? 32'd8 : 32'd6);
    chk("R6 flags after jump", 32'(dbg_flags), 32'(fl));
  endtask

  // Opcode-in-slot case after SUB: MOV (R6) or an unlisted opcode (R9).
  task automatic run_quiet(logic [7:0] op);
    logic [31:0] r, v;
    logic [5:0]  fl;
    ref_alu(8'h03, 32'd5, 32'd9, r, fl);
    clear_image();
    image[0] = ins(8'h13, 8'h01, 8'h80, 8'h00);
    image[1] = ins(8'h13, 8'h02, 8'h81, 8'h00);
    image[2] = ins(8'h03, 8'h03, 8'h01, 8'h02);
    image[3] = ins(op, 8'h00, 8'h03, 8'h03);
    image[4] = 32'hFF00_0000;
    image[8'h80] = 32'd5;
    image[8'h81] = 32'd9;
    do_reset(1'b0);
    run_prog(37);
    rd_reg(0, v);
    chk((op == 8'h01) ? "R6 MOV dest" : "R9 unlisted no write", v, (op == 8'h01) ? r : 32'h0);
    rd_reg(3, v);
    chk("R9 source kept", v, r);
    chk((op == 8'h01) ? "R6 MOV flags" : "R9 flags kept", 32'(dbg_flags), 32'(fl));
    chk("R9 pc advanced", 32'(dbg_pc), 32'd5);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0]  ops [9];
    logic [63:0] p;
    logic [7:0]  pc_hold;
    int writes;
    ops = '{8'h02, 8'h03, 8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B};
    clear_image();
    do_reset(1'b1);

    for (int o = 0; o < 9; o++) begin
      for (int k = 0; k < 9; k++) begin
        p = pair(k);
        run_alu(ops[o], p[63:32], p[31:0], 1'b0, (k % 2) == 1);
      end
      p = pair(6);
      run_alu(ops[o], p[63:32], p[31:0], 1'b1, 1'b0);
    end

    run_branch(8'h0D, 32'd7, 32'd7, 1'b1);
    run_branch(8'h0D, 32'd7, 32'd3, 1'b0);
    run_branch(8'h0E, 32'd7, 32'd7, 1'b0);
    run_branch(8'h0E, 32'd7, 32'd3, 1'b1);
    run_branch(8'h0C, 32'd7, 32'd7, 1'b1);
    run_branch(8'h0C, 32'd7, 32'd3, 1'b1);

    run_quiet(8'h01);
    run_quiet(8'h00);
    run_quiet(8'h05);
    for (int q = 8'h0F; q <= 8'h12; q++) run_quiet(8'(q));
    run_quiet(8'h15);
    run_quiet(8'h80);
    run_quiet(8'hFE);

    // R10: after halt the core stays frozen and never writes memory.
    pc_hold = dbg_pc;
    writes = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (mem_we) writes++;
    end
    chk("R10 halted held", 32'(halted), 32'h1);
    chk("R10 pc frozen", 32'(dbg_pc), 32'(pc_hold));
    chk("R10 no writes", 32'(writes), 32'h0);

    // R1: reset after a run clears the dirtied state.
    do_reset(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule